// File: doc/BRIEF.md
# Receive Frame Length Limiter

This block sits on the path between an infrared receiver's byte stream and the receive FIFO that buffers it. For every frame it counts the data bytes that arrive. It then decides, byte by byte and in the same cycle, whether each byte may be written into the FIFO. Software programs a maximum frame length of up to 13 bits. Once a frame grows beyond that length, the block drops the offending byte and every later byte of the frame. It also raises a sticky overflow flag. Normal forwarding resumes when the next start-of-frame pulse arrives.

The block has a small byte-wide register port with four addresses:

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | Limit, bits 7:0 |
| 1 | read/write | Limit, bits 12:8, held in data bits 4:0 |
| 2 | read | Live byte count, bits 7:0 |
| 3 | read | Live byte count, bits 12:8, in data bits 4:0; overflow flag in data bit 7 |

Writing a 1 to bit 7 at address 3 clears the overflow flag. The same flag is also driven on its own output port.

Top module: `rx_frame_len_limiter`

## Requirements
- R1: The 13-bit limit is written and read as two bytes. Address 0 holds limit bits 7:0. Address 1 holds limit bits 12:8 in data bits 4:0, and data bits 7:5 of address 1 always read as 0.
- R2: Each cycle with `byte_vld` high and `sof` low adds one to the byte count. Dropped bytes are counted too. The count reads at address 2 (bits 7:0) and at address 3, data bits 4:0 (bits 12:8).
- R3: A `sof` pulse clears the count to zero and re-enables forwarding. If `byte_vld` is high in the same cycle as `sof`, that byte is the first byte of the new frame: the count becomes 1 and the byte is judged against the limit.
- R4: A byte that arrives while the count is below the limit is forwarded. `fifo_wr` goes high in the same cycle as `byte_vld`. The FIFO receives min(N, limit) bytes of an N-byte frame.
- R5: The byte that would take the count past the limit is dropped, and so is every later byte of that frame. This holds even if the limit is raised in the middle of the frame.
- R6: Every dropped byte sets the overflow flag. The flag appears on `ovf_flag` and at address 3, data bit 7, from the cycle after the drop.
- R7: The overflow flag survives a `sof` pulse. It clears only when 1 is written to address 3, data bit 7. If a clear and a drop happen in the same cycle, the flag stays set.
- R8: The count saturates at 8191 and does not wrap. With a limit of 8191, exactly 8191 bytes are forwarded.
- R9: A limit of 0 drops every byte of the frame and sets the flag on the first byte.
- R10: After reset the limit, the count and the flag are 0, and `fifo_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse from the receiver |
| byte_vld | input | 1 | A received data byte is present this cycle |
| fifo_wr | output | 1 | Write strobe to the receive FIFO, same cycle as the byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 to 3) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |

## Verification
The bench builds the block with its default 13-bit width. This width keeps the saturation corner reachable: a single frame of a little over 8191 bytes fits well inside the run. Every limit from 0 to 6 is combined with every frame length from 0 to 8. This sweep covers the zero limit, the exact-limit frame and the first dropped byte at each small limit. Expected forward counts, read-back counts and flag values are computed as min(N, L), N and N > L. Directed frames add a limit that spans both bytes, a limit raised mid-frame, a start pulse that coincides with a byte, and a clear that coincides with a drop.

// File: rtl/frlim_pkg.sv
package frlim_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int CLR_BIT = 7;

    typedef enum logic [ADDR_W-1:0] {
        A_LIM_LO = 2'd0,
        A_LIM_HI = 2'd1,
        A_CNT_LO = 2'd2,
        A_CNT_HI = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic sof;
        logic vld;
    } rx_evt_t;

endpackage

// File: rtl/frlim_regs.sv
module frlim_regs
    import frlim_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    input  logic [CNT_W-1:0]     cnt,
    input  logic                 flag,
    output logic [CNT_W-1:0]     limit,
    output logic [BYTE_W-1:0]    reg_rdata,
    output logic                 flag_clr
);
    localparam int HI_W = CNT_W - BYTE_W;

    reg_addr_e        addr;
    logic [CNT_W-1:0] limit_q;

    assign addr = reg_addr_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= '0;
        end else if (reg_we) begin
            if (addr == A_LIM_LO) limit_q[BYTE_W-1:0]     <= reg_wdata;
            if (addr == A_LIM_HI) limit_q[CNT_W-1:BYTE_W] <= reg_wdata[HI_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            A_LIM_LO: reg_rdata = limit_q[BYTE_W-1:0];
            A_LIM_HI: reg_rdata = BYTE_W'(limit_q >> BYTE_W);
            A_CNT_LO: reg_rdata = cnt[BYTE_W-1:0];
            A_CNT_HI: begin
                reg_rdata          = BYTE_W'(cnt >> BYTE_W);
                reg_rdata[CLR_BIT] = flag;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign flag_clr = reg_we && (addr == A_CNT_HI) && reg_wdata[CLR_BIT];
    assign limit    = limit_q;

endmodule

// File: rtl/frlim_counter.sv
module frlim_counter
    import frlim_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  rx_evt_t          evt,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (evt.sof)
            cnt_d = evt.vld ? CNT_W'(1) : '0;
        else if (evt.vld && cnt_q != CNT_MAX)
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (evt.vld && !evt.sof && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    p_sof_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (evt.sof && !evt.vld) |=> cnt_q == '0);

    p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !evt.sof) |=> cnt_q == CNT_MAX);

endmodule

// File: rtl/frlim_gate.sv
module frlim_gate
    import frlim_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  rx_evt_t          evt,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] limit,
    input  logic             flag_clr,
    output logic             fifo_wr,
    output logic             flag
);
    logic             blocked_q, flag_q;
    logic [CNT_W-1:0] cnt_base;
    logic             blk_eff, drop;

    // A start pulse opens a new frame in the same cycle.
    assign cnt_base = evt.sof ? '0 : cnt;
    assign blk_eff  = blocked_q && !evt.sof;
    assign fifo_wr  = evt.vld && !blk_eff && (cnt_base < limit);
    assign drop     = evt.vld && !fifo_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            blocked_q <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            blocked_q <= drop || (blocked_q && !evt.sof);
            flag_q    <= drop || (flag_q && !flag_clr);
        end
    end

    assign flag = flag_q;

    p_blocked_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (blocked_q && !evt.sof) |-> !fifo_wr);

    p_flag_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(evt.vld && !fifo_wr));

    p_flag_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(flag_clr));

endmodule

// File: rtl/rx_frame_len_limiter.sv
module rx_frame_len_limiter
    import frlim_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sof,
    input  logic              byte_vld,
    output logic              fifo_wr,
    output logic              ovf_flag,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata
);
    rx_evt_t          evt;
    logic [CNT_W-1:0] cnt, limit;
    logic             flag_clr;

    assign evt.sof = sof;
    assign evt.vld = byte_vld;

    frlim_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cnt(cnt), .flag(ovf_flag),
        .limit(limit), .reg_rdata(reg_rdata), .flag_clr(flag_clr)
    );

    frlim_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .evt(evt), .cnt(cnt)
    );

    frlim_gate #(.CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst(rst), .evt(evt), .cnt(cnt), .limit(limit),
        .flag_clr(flag_clr), .fifo_wr(fifo_wr), .flag(ovf_flag)
    );

    p_under_limit_r4: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && !sof) |-> cnt < limit);

    p_zero_limit_r9: assert property (@(posedge clk) disable iff (rst)
        (limit == '0) |-> !fifo_wr);

endmodule

// File: tb/test_rx_frame_len_limiter.sv
`timescale 1ns/1ps
module test_rx_frame_len_limiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sof = 1'b0, byte_vld = 1'b0, reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       fifo_wr, ovf_flag;
    logic [7:0] reg_rdata;

    int checks = 0, fails = 0, cycles = 0;

    always #4 clk = ~clk;

    rx_frame_len_limiter #(.CNT_W(13)) i_rx_frame_len_limiter (
        .clk(clk), .rst(rst), .sof(sof), .byte_vld(byte_vld),
        .fifo_wr(fifo_wr), .ovf_flag(ovf_flag), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input int a, output int d);
        @(negedge clk);
        reg_addr = 2'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic set_limit(input int l);
        wr_reg(0, l & 8'hFF);
        wr_reg(1, (l >> 8) & 8'hFF);
    endtask

    task automatic pulse_sof;
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
    endtask

    task automatic send(input int n, output int w);
        w = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            #1 if (fifo_wr) w++;
        end
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic read_state(output int cnt, output int flg);
        int lo, hi;
        rd_reg(2, lo);
        rd_reg(3, hi);
        cnt = lo | ((hi & 8'h1F) << 8);
        flg = (hi >> 7) & 1;
    endtask

    int w, c, f, d, e;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        for (int a = 0; a < 4; a++) begin
            rd_reg(a, d);
            check(d == 0, "R10 reset read", d, 0);
        end
        check(fifo_wr == 1'b0 && ovf_flag == 1'b0, "R10 outputs", int'(fifo_wr), 0);

        // R1: limit readback across both bytes
        wr_reg(0, 8'hA5); wr_reg(1, 8'hFF);
        rd_reg(0, d); check(d == 8'hA5, "R1 low byte", d, 8'hA5);
        rd_reg(1, d); check(d == 8'h1F, "R1 high byte", d, 8'h1F);

        // Sweep: limits 0..6 x lengths 0..8 (R2 R4 R5 R6 R7 R9)
        for (int l = 0; l <= 6; l++) begin
            for (int n = 0; n <= 8; n++) begin
                set_limit(l);
                pulse_sof;
                read_state(c, f);
                check(c == 0, "R3 count after sof", c, 0);
                send(n, w);
                e = (n < l) ? n : l;
                check(w == e, (l == 0) ? "R9 zero limit writes" : "R4 R5 forwarded", w, e);
                read_state(c, f);
                check(c == n, "R2 count", c, n);
                check(f == int'(n > l), "R6 flag", f, int'(n > l));
                check(int'(ovf_flag) == int'(n > l), "R6 flag port", int'(ovf_flag), int'(n > l));
                wr_reg(3, 8'h80);
                read_state(c, f);
                check(f == 0, "R7 clear", f, 0);
            end
        end

        // R1 R4 R5: limit spanning both bytes
        set_limit(300); pulse_sof; send(302, w);
        check(w == 300, "R1 R4 two-byte limit", w, 300);
        read_state(c, f);
        check(c == 302 && f == 1, "R2 R6 two-byte limit", c, 302);

        // R7: sticky across sof, set wins over clear
        set_limit(1); pulse_sof; send(2, w);
        pulse_sof;
        read_state(c, f);
        check(f == 1, "R7 sticky across sof", f, 1);
        send(1, w);
        send(1, w);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h80; byte_vld = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; byte_vld = 1'b0;
        read_state(c, f);
        check(f == 1, "R7 set beats clear", f, 1);
        wr_reg(3, 8'h80);
        read_state(c, f);
        check(f == 0, "R7 clear alone", f, 0);

        // R5: raising the limit mid-frame keeps the frame blocked
        set_limit(2); pulse_sof; send(3, w);
        set_limit(10); send(2, w);
        check(w == 0, "R5 blocked after raise", w, 0);
        read_state(c, f);
        check(c == 5, "R2 count while blocked", c, 5);

        // R3: sof coincident with a byte
        @(negedge clk);
        sof = 1'b1; byte_vld = 1'b1;
        #1 check(fifo_wr == 1'b1, "R3 sof with byte forwarded", int'(fifo_wr), 1);
        @(negedge clk);
        sof = 1'b0; byte_vld = 1'b0;
        read_state(c, f);
        check(c == 1, "R3 sof with byte count", c, 1);
        wr_reg(3, 8'h80);

        // R8: saturation
        set_limit(8191); pulse_sof; send(8195, w);
        check(w == 8191, "R8 forwarded at max", w, 8191);
        read_state(c, f);
        check(c == 8191, "R8 saturated count", c, 8191);
        check(f == 1, "R8 flag at max", f, 1);

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule